// File: doc/BRIEF.md
# Voltage-Scaling Clock Update Sequencer

This block controls frequency changes in an adaptive supply-voltage loop. A frequency command arrives as a clock-divider select code. The block moves two select codes, one for the controller test clock and one for the application clock, in the order that keeps the application safe.

When the application is to slow down, both selects move together at the divider's next synchronization point. The supply is allowed to fall afterwards. When the application is to speed up, only the controller clock moves at first. The block then waits for that change to take effect and for half an application-clock period. It waits for its built-in supply-ready detector to report a settled supply, and only then raises the application clock at a synchronization point.

The supply-ready detector watches one sampled delay-line tap, the one just below the critical-path point, and asserts after a run of consecutive 1 samples.

All pins are plain control levels or single-cycle strobes sampled on `clk`. There is no streaming interface, so no back-pressure applies. A larger select code means a slower clock.

Top module: `avs_clk_sequencer`

## Requirements
- R1: After reset, `avs_sel` and `app_sel` both equal the parameter `RESET_SEL` (default 4), `busy` is 0 and `supply_ok` is 0.
- R2: `supply_ok` becomes 1 at the clock edge that takes the `RUN_LEN`-th consecutive `tap_below`=1 sample (default 8), counting only cycles with `tap_valid`=1. Cycles with `tap_valid`=0 neither extend nor break the run.
- R3: A sample with `tap_valid`=1 and `tap_below`=0 clears the run, and `supply_ok` is 0 from that same edge.
- R4: In idle, a `freq_cmd` that differs from `app_sel` is latched as the target and `busy` rises at that edge. A `freq_cmd` equal to `app_sel` starts nothing. Command changes while `busy` is 1 are ignored. A command that still differs from `app_sel` after completion starts a new update.
- R5: A target code larger than `app_sel` (slow-down) sets both `avs_sel` and `app_sel` to the target at the next `sync_pt` strobe, whatever the value of `supply_ok`.
- R6: A target code smaller than `app_sel` (speed-up) sets only `avs_sel` to the target at the next `sync_pt` strobe.
- R7: During a speed-up, `app_sel` stays unchanged until these events have occurred in this order: an `avs_switched` strobe, then an `app_half_tick` strobe, then `supply_ok`=1. Only then is `app_sel` set equal to `avs_sel`, at the next `sync_pt`.
- R8: `busy` returns to 0 at the edge that takes the final switched strobe. For a speed-up that strobe is `app_switched`. For a slow-down it is the later of `avs_switched` and `app_switched`, which may arrive in either order.
- R9: `app_sel` is never numerically smaller than `avs_sel`, and the two are equal whenever `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Active-low synchronous reset |
| freq_cmd | input | SEL_W | Requested divider select code |
| tap_valid | input | 1 | One pulse per controller-clock cycle with a new tap sample |
| tap_below | input | 1 | Sampled delay-line tap just below the critical-path point |
| sync_pt | input | 1 | Divider synchronization point strobe |
| avs_switched | input | 1 | Divider reports the controller clock select took effect |
| app_switched | input | 1 | Divider reports the application clock select took effect |
| app_half_tick | input | 1 | Strobe at each application-clock half period |
| avs_sel | output | SEL_W | Controller clock select code |
| app_sel | output | SEL_W | Application clock select code |
| busy | output | 1 | An update is in progress |
| supply_ok | output | 1 | Supply-ready flag |

## Verification
Every result here is registered once. A latched command shows on `busy`, a strobe moves a select code, and a tap sample moves `supply_ok`, each visible after exactly one rising edge. One exception: a speed-up becomes eligible for its application update one edge after `supply_ok` rises, so the bench leaves a spare cycle before offering a synchronization point. The bench changes inputs on a falling edge, holds each strobe for one cycle, and reads outputs on the following falling edge, so each check lands half a cycle after the edge that produced its result. The waits in the speed-up path are checked by offering `sync_pt` while each earlier condition is still missing and confirming that `app_sel` does not move.

// File: rtl/avs_seq_pkg.sv
package avs_seq_pkg;
  typedef enum logic [3:0] {
    S_IDLE,
    S_UP_SYNC,
    S_UP_AVS_ACK,
    S_UP_HALF,
    S_UP_WAIT_OK,
    S_UP_APP_SYNC,
    S_UP_APP_ACK,
    S_DN_SYNC,
    S_DN_ACK
  } seq_state_e;
endpackage

// File: rtl/avs_ready_detect.sv
module avs_ready_detect #(
  parameter int RUN_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tap_valid,
  input  logic tap_bit,
  output logic ready
);
  localparam int CW = $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0] FULL = CW'(RUN_LEN);

  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_cnt <= '0;
    end else if (tap_valid) begin
      if (!tap_bit)
        run_cnt <= '0;
      else if (run_cnt != FULL)
        run_cnt <= run_cnt + CW'(1);
    end
  end

  assign ready = (run_cnt == FULL);

  // R3
  zero_clears_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tap_valid && !tap_bit) |=> !ready);

  // R2
  ready_needs_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(tap_valid && tap_bit));
endmodule

// File: rtl/avs_seq_ctrl.sv
module avs_seq_ctrl
  import avs_seq_pkg::*;
#(
  parameter int SEL_W     = 4,
  parameter int RESET_SEL = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] freq_cmd,
  input  logic             sync_pt,
  input  logic             avs_switched,
  input  logic             app_switched,
  input  logic             app_half_tick,
  input  logic             ready,
  output logic [SEL_W-1:0] avs_sel,
  output logic [SEL_W-1:0] app_sel,
  output logic             busy
);
  localparam logic [SEL_W-1:0] RST_CODE = SEL_W'(RESET_SEL);

  seq_state_e       state;
  logic [SEL_W-1:0] target;
  logic [SEL_W-1:0] avs_q, app_q;
  logic             avs_seen, app_seen;
  logic             dn_done;

  assign dn_done = (avs_seen | avs_switched) & (app_seen | app_switched);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      target   <= RST_CODE;
      avs_q    <= RST_CODE;
      app_q    <= RST_CODE;
      avs_seen <= 1'b0;
      app_seen <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (freq_cmd != app_q) begin
            target <= freq_cmd;
            state  <= (freq_cmd < app_q) ? S_UP_SYNC : S_DN_SYNC;
          end
        end
        S_UP_SYNC: begin
          if (sync_pt) begin
            avs_q <= target;
            state <= S_UP_AVS_ACK;
          end
        end
        S_UP_AVS_ACK: if (avs_switched)  state <= S_UP_HALF;
        S_UP_HALF:    if (app_half_tick) state <= S_UP_WAIT_OK;
        S_UP_WAIT_OK: if (ready)         state <= S_UP_APP_SYNC;
        S_UP_APP_SYNC: begin
          if (sync_pt) begin
            app_q <= avs_q;
            state <= S_UP_APP_ACK;
          end
        end
        S_UP_APP_ACK: if (app_switched) state <= S_IDLE;
        S_DN_SYNC: begin
          if (sync_pt) begin
            avs_q    <= target;
            app_q    <= target;
            avs_seen <= 1'b0;
            app_seen <= 1'b0;
            state    <= S_DN_ACK;
          end
        end
        S_DN_ACK: begin
          if (avs_switched) avs_seen <= 1'b1;
          if (app_switched) app_seen <= 1'b1;
          if (dn_done)      state    <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign avs_sel = avs_q;
  assign app_sel = app_q;
  assign busy    = (state != S_IDLE);

  // R9
  app_not_faster_chk: assert property (@(posedge clk) disable iff (!rst_n)
    app_q >= avs_q);

  // R9
  idle_matched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (avs_q == app_q));

  // R4
  target_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || $stable(target)));

  // R5
  sel_only_at_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_pt |=> ($stable(avs_q) && $stable(app_q)));

  // R7
  app_up_after_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_UP_HALF) |=> (app_q == $past(app_q)));
endmodule

// File: rtl/avs_clk_sequencer.sv
module avs_clk_sequencer #(
  parameter int SEL_W     = 4,
  parameter int RESET_SEL = 4,
  parameter int RUN_LEN   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] freq_cmd,
  input  logic             tap_valid,
  input  logic             tap_below,
  input  logic             sync_pt,
  input  logic             avs_switched,
  input  logic             app_switched,
  input  logic             app_half_tick,
  output logic [SEL_W-1:0] avs_sel,
  output logic [SEL_W-1:0] app_sel,
  output logic             busy,
  output logic             supply_ok
);
  logic ready_w;

  avs_ready_detect #(.RUN_LEN(RUN_LEN)) u_detect (
    .clk       (clk),
    .rst_n     (rst_n),
    .tap_valid (tap_valid),
    .tap_bit   (tap_below),
    .ready     (ready_w)
  );

  avs_seq_ctrl #(.SEL_W(SEL_W), .RESET_SEL(RESET_SEL)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .freq_cmd      (freq_cmd),
    .sync_pt       (sync_pt),
    .avs_switched  (avs_switched),
    .app_switched  (app_switched),
    .app_half_tick (app_half_tick),
    .ready         (ready_w),
    .avs_sel       (avs_sel),
    .app_sel       (app_sel),
    .busy          (busy)
  );

  assign supply_ok = ready_w;
endmodule

// File: tb/avs_clk_sequencer_bench.sv
module avs_clk_sequencer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] freq_cmd = 4'd4;
  logic       tap_valid = 1'b0, tap_below = 1'b0;
  logic       sync_pt = 1'b0, avs_switched = 1'b0, app_switched = 1'b0;
  logic       app_half_tick = 1'b0;
  logic [3:0] avs_sel, app_sel;
  logic       busy, supply_ok;
  int         n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  avs_clk_sequencer u_avs_clk_sequencer (
    .clk(clk), .rst_n(rst_n), .freq_cmd(freq_cmd),
    .tap_valid(tap_valid), .tap_below(tap_below), .sync_pt(sync_pt),
    .avs_switched(avs_switched), .app_switched(app_switched),
    .app_half_tick(app_half_tick), .avs_sel(avs_sel), .app_sel(app_sel),
    .busy(busy), .supply_ok(supply_ok)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic sample(bit b);
    tap_valid = 1'b1; tap_below = b; tick(); tap_valid = 1'b0;
  endtask

  task automatic pulse_sync();
    sync_pt = 1'b1; tick(); sync_pt = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; repeat (3) tick(); rst_n = 1'b1;
    chk("R1 avs_sel", avs_sel, 4);
    chk("R1 app_sel", app_sel, 4);
    chk("R1 busy", busy, 0);
    chk("R1 supply_ok", supply_ok, 0);
  endtask

  task automatic t_ready_run();
    for (int i = 0; i < 7; i++) begin
      sample(1'b1);
      tap_below = 1'b0; tick();   // gap without tap_valid (R2)
    end
    chk("R2 ok after 7 ones", supply_ok, 0);
    sample(1'b1);
    chk("R2 ok after 8 ones", supply_ok, 1);
    sample(1'b0);
    chk("R3 ok cleared by zero", supply_ok, 0);
    for (int i = 0; i < 7; i++) sample(1'b1);
    chk("R3 run restarted", supply_ok, 0);
    sample(1'b0);
  endtask

  task automatic t_slow_down();
    freq_cmd = 4'd6; tick();
    chk("R4 busy on latch", busy, 1);
    chk("R5 avs before sync", avs_sel, 4);
    pulse_sync();
    chk("R5 avs at sync", avs_sel, 6);
    chk("R5 app at sync", app_sel, 6);
    app_switched = 1'b1; tick(); app_switched = 1'b0;
    chk("R8 busy after one strobe", busy, 1);
    avs_switched = 1'b1; tick(); avs_switched = 1'b0;
    chk("R8 busy after both strobes", busy, 0);
  endtask

  task automatic t_speed_up();
    for (int i = 0; i < 8; i++) sample(1'b1);
    chk("R2 ok primed", supply_ok, 1);
    freq_cmd = 4'd2; tick();
    chk("R4 busy speed-up", busy, 1);
    freq_cmd = 4'd9;            // ignored while busy (R4)
    pulse_sync();
    chk("R6 avs moved", avs_sel, 2);
    chk("R6 app held", app_sel, 6);
    pulse_sync();
    chk("R7 app held before avs strobe", app_sel, 6);
    avs_switched = 1'b1; tick(); avs_switched = 1'b0;
    pulse_sync();
    chk("R7 app held before half tick", app_sel, 6);
    sample(1'b0);
    app_half_tick = 1'b1; tick(); app_half_tick = 1'b0;
    pulse_sync();
    chk("R7 app held without ready", app_sel, 6);
    for (int i = 0; i < 8; i++) sample(1'b1);
    tick();
    pulse_sync();
    chk("R7 app raised", app_sel, 2);
    chk("R4 ignored cmd avs", avs_sel, 2);
    chk("R8 busy before app strobe", busy, 1);
    app_switched = 1'b1; tick(); app_switched = 1'b0;
    chk("R8 busy done", busy, 0);
    chk("R9 idle matched", avs_sel, app_sel);
    tick();
    chk("R4 pending cmd restarts", busy, 1);
    pulse_sync();
    chk("R5 both to 9", app_sel * 16 + avs_sel, 9 * 16 + 9);
    avs_switched = 1'b1; app_switched = 1'b1; tick();
    avs_switched = 1'b0; app_switched = 1'b0;
    chk("R8 same-cycle strobes", busy, 0);
  endtask

  task automatic t_same_cmd();
    repeat (4) tick();
    chk("R4 equal cmd idle", busy, 0);
    chk("R4 equal cmd sel", app_sel, 9);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    tick();
    t_reset();
    t_ready_run();
    t_slow_down();
    t_speed_up();
    t_same_cmd();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule